// File: doc/BRIEF.md
# Tagless Last-Target Indirect Branch Predictor

This block predicts the destination of indirect branches. It holds a direct-mapped table that is indexed by a slice of the branch address. Each entry stores the last target that any branch mapping to that slot resolved to. The table has no tags, so branches whose addresses share the index slice also share one entry. There is no hysteresis: every lookup writes back the resolved target, whether or not the prediction was right.

A request carries the branch address and its resolved target under a valid strobe. One cycle later the block returns the target that was stored before the request, together with a flag that is set when that stored target differs from the resolved one. After reset a walker clears every entry to zero, one entry per cycle. A busy output stays high while the walk runs, and requests made during that time are dropped.

The table is a single-port, read-first memory with a registered read, so it maps onto one block RAM.

Top module: `itgt_predictor`

## Requirements
- R1: After reset is released, `busy` is high for exactly 2^IDX_W clock cycles and then low, and `rsp_valid` is low throughout that time.
- R2: A request made while `busy` is high produces no response, and it leaves the table unchanged: a later lookup of that entry still returns zero.
- R3: A request accepted at a clock edge (`req_valid` high and `busy` low) raises `rsp_valid` for the following cycle only.
- R4: The entry index is `req_pc[LO_DROP +: IDX_W]`. Address bits outside this slice have no effect, so two addresses with the same slice share one entry.
- R5: The response `rsp_pred` equals the target most recently written to the indexed entry. Every entry reads zero after the reset walk.
- R6: `rsp_miss` is high exactly when `rsp_valid` is high and `rsp_pred` differs from the resolved target of that request. It is low whenever `rsp_valid` is low.
- R7: Every accepted request overwrites its entry with its resolved target, on a hit as well as on a miss.
- R8: For two back-to-back requests to the same entry, the second one predicts the first one's resolved target.
- R9: With no request, `rsp_valid` and `rsp_miss` stay low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clearing walk |
| req_valid | input | 1 | Lookup and update strobe |
| req_pc | input | ADDR_W | Branch instruction address |
| req_actual | input | ADDR_W | Resolved target of the branch |
| busy | output | 1 | High while the table is being cleared |
| rsp_valid | output | 1 | Response strobe, one cycle after an accepted request |
| rsp_pred | output | ADDR_W | Stored target before this request's update |
| rsp_miss | output | 1 | Prediction differs from the resolved target |

## Verification
The bench runs a 16-entry configuration. A first sweep over every index expects zero predictions and misses, which shows the walk cleared the table. A repeat sweep with the same targets expects hits, and that pass separates a working write-back from a missing one. A third sweep uses addresses whose upper and dropped low bits differ but whose index slice matches, and expects the earlier targets back; this separates a correct index slice from a shifted one. Back-to-back same-entry pairs, a request made during the walk, and a change of target that includes zero complete the corner cases.

// File: rtl/itgt_pkg.sv
package itgt_pkg;
  typedef enum logic {
    PH_CLEAR = 1'b0,
    PH_RUN   = 1'b1
  } phase_e;
endpackage

// File: rtl/itgt_index.sv
module itgt_index #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 9,
  parameter int LO_DROP = 2
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx
);
  logic unused_pc_bits;
  assign unused_pc_bits = ^pc;
  assign idx = pc[LO_DROP +: IDX_W];
endmodule

// File: rtl/itgt_clear.sv
module itgt_clear #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] clr_idx
);
  import itgt_pkg::*;
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CLEAR;
      clr_idx <= '0;
    end else if (phase_q == PH_CLEAR) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == LAST) phase_q <= PH_RUN;
    end
  end

  assign busy = (phase_q == PH_CLEAR);
endmodule

// File: rtl/itgt_ram.sv
module itgt_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/itgt_predictor.sv
module itgt_predictor #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 9,
  parameter int LO_DROP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_actual,
  output logic              busy,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_pred,
  output logic              rsp_miss
);
  logic [IDX_W-1:0]  req_idx;
  logic [IDX_W-1:0]  clr_idx;
  logic [IDX_W-1:0]  port_addr;
  logic [ADDR_W-1:0] port_wdata;
  logic [ADDR_W-1:0] port_rdata;
  logic              port_we;
  logic              accept;
  logic              valid_q;
  logic [ADDR_W-1:0] actual_q;

  itgt_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_DROP(LO_DROP)) u_index (
    .pc  (req_pc),
    .idx (req_idx)
  );

  itgt_clear #(.IDX_W(IDX_W)) u_clear (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .clr_idx (clr_idx)
  );

  assign accept     = req_valid & ~busy;
  assign port_addr  = busy ? clr_idx : req_idx;
  assign port_wdata = busy ? '0 : req_actual;
  assign port_we    = busy | req_valid;

  itgt_ram #(.AW(IDX_W), .DW(ADDR_W)) u_ram (
    .clk   (clk),
    .en    (port_we),
    .we    (port_we),
    .addr  (port_addr),
    .wdata (port_wdata),
    .rdata (port_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= accept;
    if (accept) actual_q <= req_actual;
  end

  assign rsp_valid = valid_q;
  assign rsp_pred  = port_rdata;
  assign rsp_miss  = valid_q & (port_rdata != actual_q);
endmodule

// File: rtl/itgt_checker.sv
module itgt_checker #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 9,
  parameter int LO_DROP = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_pc,
  input logic [ADDR_W-1:0] req_actual,
  input logic              busy,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_pred,
  input logic              rsp_miss
);
  localparam int DEPTH = 1 << IDX_W;
  logic [IDX_W:0]   since_rst;
  logic [IDX_W-1:0] cur_idx;
  logic             acc;

  assign cur_idx = req_pc[LO_DROP +: IDX_W];
  assign acc     = req_valid & ~busy;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != DEPTH[IDX_W:0]) since_rst <= since_rst + 1'b1;
  end

  assert_busy_window_R1: assert property (@(posedge clk) disable iff (rst)
    busy == (since_rst < DEPTH[IDX_W:0]));

  assert_drop_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> !rsp_valid);

  assert_resp_next_R3: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid);

  assert_miss_match_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_miss == (rsp_pred != $past(req_actual))));

  assert_same_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && $past(acc) && cur_idx == $past(cur_idx)) |=> (rsp_pred == $past(req_actual, 2)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_miss));
endmodule

bind itgt_predictor itgt_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_DROP(LO_DROP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_pc     (req_pc),
  .req_actual (req_actual),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .rsp_pred   (rsp_pred),
  .rsp_miss   (rsp_miss)
);

// File: tb/sim_itgt_predictor.sv
module sim_itgt_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int LD = 2;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_pc = '0;
  logic [AW-1:0] req_actual = '0;
  logic          busy, rsp_valid, rsp_miss;
  logic [AW-1:0] rsp_pred;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  itgt_predictor #(.ADDR_W(AW), .IDX_W(IW), .LO_DROP(LD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_pc(req_pc),
    .req_actual(req_actual), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_pred(rsp_pred), .rsp_miss(rsp_miss)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input string tag);
    int idx;
    idx = (int'(pc) >> LD) % N;
    req_valid = 1'b1; req_pc = pc; req_actual = tgt;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {{(AW-1){1'b0}}, rsp_valid}, 1);
    check({tag, " pred"}, rsp_pred, model[idx]);
    check({tag, " miss"}, {{(AW-1){1'b0}}, rsp_miss}, {{(AW-1){1'b0}}, model[idx] != tgt});
    model[idx] = tgt;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bc;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 busy at reset", {{(AW-1){1'b0}}, busy}, 1);
    check("R1 rsp_valid at reset", {{(AW-1){1'b0}}, rsp_valid}, 0);
    bc = 0;
    while (busy && bc < 100) begin
      if (bc == 13) begin
        req_valid = 1'b1; req_pc = 16'h0000; req_actual = 16'hBEEF;
      end
      if (bc == 14) begin
        check("R2 no response while busy", {{(AW-1){1'b0}}, rsp_valid}, 0);
        req_valid = 1'b0;
      end
      bc++;
      @(negedge clk);
    end
    check("R1 busy length", AW'(bc), AW'(N));
    @(negedge clk);
    check("R9 idle valid", {{(AW-1){1'b0}}, rsp_valid}, 0);
    check("R9 idle miss", {{(AW-1){1'b0}}, rsp_miss}, 0);
    // R2: the dropped request left entry 0 at zero
    do_req(16'h0000, 16'h1234, "R2");
    // R5: cleared table, then fill
    for (int i = 0; i < N; i++) do_req(AW'(i << LD), AW'(16'h1000 + i * 7), "R5");
    // R6/R7: same targets again give hits
    for (int i = 0; i < N; i++) do_req(AW'(i << LD), AW'(16'h1000 + i * 7), "R7");
    // R4: aliases through upper and dropped low bits
    for (int i = 0; i < N; i++) do_req(AW'(16'hA003 | (i << LD)), AW'(16'h2000 + i), "R4");
    // R3/R8: back-to-back to the same entry
    do_req(16'h0010, 16'h5555, "R8");
    do_req(16'h8010, 16'h6666, "R8");
    do_req(16'h4012, 16'h7777, "R3");
    // R7: overwrite after a miss, including a zero target
    do_req(16'h0020, 16'h0000, "R7");
    do_req(16'h0020, 16'h0000, "R6");
    do_req(16'h0020, 16'hFFFF, "R6");
    @(negedge clk);
    check("R9 idle after traffic", {{(AW-1){1'b0}}, rsp_valid}, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule